// File: doc/BRIEF.md
# Host Register Port with Indirect Window

This block is the slave side of an asynchronous, SRAM-style host bus. A host selects it with a chip select, asserts a read or write strobe, presents a 4-bit address and waits for the acknowledge. The 4-bit address reaches sixteen direct locations. Two of them are windows into a larger internal register file. That file is a plain single-port memory and is reached only through a separate internal address register.

The two windows differ only in how wide each host transfer is. The control window moves 16 or 32 bits per access, chosen by a configuration pin. The data window moves 8, 16 or 32 bits per access, chosen by its own pin, so a narrow controller and a wide data path can share the same pins. Partial transfers are packed big-endian: the first chunk of a word is its most significant part. Each chunk travels left-justified on the bus, in the upper bits. A word reaches the file only when its last chunk is written. After each completed word the internal address can step forward by one, so a block of registers can be streamed without rewriting the address.

The internal register file is not cleared by reset.

Top module: `hreg_port`

## Requirements
- R1: The 4-bit address selects one of 16 direct locations. Locations 4 to 15 are 32-bit read/write scratch words that read back the last value written.
- R2: Location 0 reads the fixed identity word `ID_WORD`. A write to it changes nothing.
- R3: Location 1 is the internal address register. Bits [IDX_AW-1:0] hold the internal address and bit 15 is the increment enable. It reads back in the same layout with all other bits zero. Writing it also restarts the chunk position at the start of a word.
- R4: Location 2 is the control window. With `ctl_wide_i`=1 each access carries a whole 32-bit word. With `ctl_wide_i`=0 a word takes two accesses, each carrying 16 bits on `wdata_i[31:16]`, high half first. Only the second write stores the word.
- R5: Location 3 is the data window. `dwidth_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits per access. Chunks are taken from the top bits of `wdata_i`, and the first chunk is the most significant. Bus bits below the chunk are ignored, and the word is stored after its final chunk.
- R6: A read of either window returns the next chunk of the word at the internal address. The chunks come in the same order as on write, left-justified, with all lower bits zero.
- R7: With the increment enable set, the internal address advances by one after each completed word in either direction. With it clear, the address stays where it is.
- R8: `ack_o` rises on the first clock edge that samples `cs_i` together with `rd_i` or `wr_i`. It stays high while that strobe is held and falls on the first edge that samples the strobe released. Each strobe performs exactly one access.
- R9: After reset, `ack_o` and `rdata_o` are 0, the internal address is 0, the increment enable is off and the chunk position is at the start of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Direct location |
| wdata_i | input | 32 | Write data, left-justified |
| ctl_wide_i | input | 1 | Control window width: 1 = 32 bits, 0 = 16 bits |
| dwidth_i | input | 2 | Data window width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| rdata_o | output | 32 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | Access acknowledge |

## Verification
The bench writes only the first half of a word through the 16-bit control window. It then moves the address and reads the word back whole. A design that commits on the first half would show the stale half mixed with the new one. Byte-wide writes carry junk in the unused low bus bits, so a design that fails to mask or shift chunks corrupts neighbouring bytes. Narrow reads of a stored word check both the big-endian order and the zero fill. Reads of the address register after streaming catch an increment that fires per chunk instead of per word, or one that fires with the enable clear. Repeated writes to the identity location, and strobes held for two cycles, expose a writable identity word and an access repeated on every held cycle.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2
  } wsel_t;

  // direct map positions that the host software relies on
  localparam logic [3:0] LOC_ID    = 4'd0;
  localparam logic [3:0] LOC_IADDR = 4'd1;
  localparam logic [3:0] LOC_CWIN  = 4'd2;
  localparam logic [3:0] LOC_DWIN  = 4'd3;
  localparam logic [3:0] LOC_SCR0  = 4'd4;
  localparam int         INC_BIT   = 15;

  function automatic logic [2:0] wsel_bytes(input wsel_t w);
    case (w)
      WSEL_8:  wsel_bytes = 3'd1;
      WSEL_16: wsel_bytes = 3'd2;
      default: wsel_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/hreg_strobe.sv
module hreg_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic rd_i,
  input  logic wr_i,
  output logic ack_o,
  output logic fire_rd,
  output logic fire_wr
);
  logic strobe;
  logic fire;

  assign strobe  = cs_i & (rd_i | wr_i);
  assign fire    = strobe & ~ack_o;
  assign fire_rd = fire & rd_i;
  assign fire_wr = fire & wr_i & ~rd_i;

  always_ff @(posedge clk) begin
    if (rst) ack_o <= 1'b0;
    else     ack_o <= strobe;
  end
endmodule

// File: rtl/hreg_lane.sv
module hreg_lane
  import hreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  wsel_t                       wsel,
  input  logic [$clog2(DW/8)-1:0]     ptr,
  input  logic [DW-1:0]               bus_wdata,
  input  logic [DW-1:0]               acc,
  input  logic [DW-1:0]               word,
  output logic [DW-1:0]               acc_next,
  output logic [DW-1:0]               rchunk,
  output logic [$clog2(DW/8)-1:0]     ptr_next,
  output logic                        last
);
  localparam int             NB   = DW / 8;
  localparam int             PW   = $clog2(NB);
  localparam logic [PW:0]    NB_V = (PW+1)'(NB);

  logic [PW:0]   nb;
  logic [PW:0]   sum;
  logic [DW-1:0] top;
  logic [PW+2:0] sh;

  always_comb begin
    nb       = (PW+1)'(wsel_bytes(wsel));
    sum      = {1'b0, ptr} + nb;
    last     = (sum >= NB_V);
    ptr_next = last ? '0 : sum[PW-1:0];
    top      = ~({DW{1'b1}} >> {nb, 3'b000});
    sh       = {1'b0, ptr, 3'b000};
    acc_next = (acc & ~(top >> sh)) | ((bus_wdata & top) >> sh);
    rchunk   = (word << sh) & top;
  end
endmodule

// File: rtl/hreg_ram.sv
module hreg_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hreg_port.sv
module hreg_port
  import hreg_pkg::*;
#(
  parameter int            IDX_AW  = 6,
  parameter int            DW      = 32,
  parameter logic [DW-1:0] ID_WORD = 32'h4852_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ctl_wide_i,
  input  logic [1:0]    dwidth_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o
);
  localparam int NSCR = 16 - int'(LOC_SCR0);
  localparam int PW   = $clog2(DW/8);

  logic              fire_rd, fire_wr;
  logic [IDX_AW-1:0] iaddr;
  logic              inc_en;
  logic [PW-1:0]     ptr, ptr_next;
  logic [DW-1:0]     acc, acc_next, rchunk, ram_q;
  logic [DW-1:0]     scr [NSCR];
  logic              last, is_win, commit;
  wsel_t             wsel;
  logic [DW-1:0]     iaddr_word;
  logic [3:0]        sidx;

  hreg_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .ack_o(ack_o), .fire_rd(fire_rd), .fire_wr(fire_wr)
  );

  // window width: control window follows ctl_wide_i, data window dwidth_i
  always_comb begin
    if (addr_i == LOC_CWIN) wsel = ctl_wide_i ? WSEL_32 : WSEL_16;
    else begin
      case (dwidth_i)
        2'd0:    wsel = WSEL_8;
        2'd1:    wsel = WSEL_16;
        default: wsel = WSEL_32;
      endcase
    end
  end

  assign is_win = (addr_i == LOC_CWIN) || (addr_i == LOC_DWIN);
  assign commit = fire_wr & is_win & last;
  assign sidx   = addr_i - LOC_SCR0;

  hreg_lane #(.DW(DW)) u_lane (
    .wsel(wsel), .ptr(ptr), .bus_wdata(wdata_i), .acc(acc), .word(ram_q),
    .acc_next(acc_next), .rchunk(rchunk), .ptr_next(ptr_next), .last(last)
  );

  hreg_ram #(.AW(IDX_AW), .DW(DW)) u_ram (
    .clk(clk), .we(commit), .waddr(iaddr), .wdata(acc_next),
    .raddr(iaddr), .rdata(ram_q)
  );

  always_comb begin
    iaddr_word                 = '0;
    iaddr_word[IDX_AW-1:0]     = iaddr;
    iaddr_word[INC_BIT]        = inc_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iaddr   <= '0;
      inc_en  <= 1'b0;
      ptr     <= '0;
      acc     <= '0;
      rdata_o <= '0;
      for (int i = 0; i < NSCR; i++) scr[i] <= '0;
    end else begin
      if (fire_wr) begin
        if (addr_i == LOC_IADDR) begin
          iaddr  <= wdata_i[IDX_AW-1:0];
          inc_en <= wdata_i[INC_BIT];
          ptr    <= '0;
        end else if (is_win) begin
          acc <= acc_next;
          ptr <= ptr_next;
          if (last && inc_en) iaddr <= iaddr + 1'b1;
        end else if (addr_i >= LOC_SCR0) begin
          scr[sidx] <= wdata_i;
        end
      end
      if (fire_rd) begin
        if (addr_i == LOC_ID) rdata_o <= ID_WORD;
        else if (addr_i == LOC_IADDR) rdata_o <= iaddr_word;
        else if (is_win) begin
          rdata_o <= rchunk;
          ptr     <= ptr_next;
          if (last && inc_en) iaddr <= iaddr + 1'b1;
        end else rdata_o <= scr[sidx];
      end
    end
  end
endmodule

// File: rtl/hreg_port_chk.sv
module hreg_port_chk #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] ID_WORD = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [3:0]    addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          ack_o
);
  logic strobe;
  logic rst_d;
  assign strobe = cs_i && (rd_i || wr_i);

  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_o && strobe) |=> ack_o);

  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !ack_o);

  assert_ack_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(strobe));

  assert_id_read_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_o) && cs_i && rd_i && addr_i == 4'd0) |-> rdata_o == ID_WORD);

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_o && $past(ack_o)) |-> $stable(rdata_o));

  always @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) assert_reset_R9: assert (!ack_o && rdata_o == '0);
  end
endmodule

bind hreg_port hreg_port_chk #(.DW(DW), .ID_WORD(ID_WORD)) u_chk (
  .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .ack_o(ack_o)
);

// File: tb/test_hreg_port.sv
module test_hreg_port;
  localparam logic [31:0] ID = 32'h4852_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_i = 0, rd_i = 0, wr_i = 0, ctl_wide_i = 1;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  dwidth_i = 2'd2;
  logic [31:0] rdata_o;
  logic        ack_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          is_rd = 0;
  logic        prev_ack = 0;

  always #2.5 clk = ~clk;

  hreg_port #(.ID_WORD(ID)) i_hreg_port (
    .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ctl_wide_i(ctl_wide_i),
    .dwidth_i(dwidth_i), .rdata_o(rdata_o), .ack_o(ack_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: on each rising ack of a read, compare against the scoreboard
  always @(negedge clk) begin
    if (ack_o && !prev_ack && is_rd) begin
      if (exp_q.size() == 0) check("R8 unexpected read ack", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
    prev_ack = ack_o;
  end

  task automatic access(input bit rd, input logic [3:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    is_rd = rd; cs_i = 1; rd_i = rd; wr_i = !rd; addr_i = a; wdata_i = d;
    @(negedge clk);
    check("R8 ack rises", {31'b0, ack_o}, 32'h1);
    @(negedge clk);
    check("R8 ack held", {31'b0, ack_o}, 32'h1);
    cs_i = 0; rd_i = 0; wr_i = 0; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R8 ack falls", {31'b0, ack_o}, 32'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    access(0, a, d, '0, "");
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    access(1, a, '0, exp, tag);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 ack after reset", {31'b0, ack_o}, 32'h0);
    check("R9 rdata after reset", rdata_o, 32'h0);
    rd(4'd1, 32'h0, "R9 address register after reset");

    rd(4'd0, ID, "R2 identity read");
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, ID, "R2 identity after write");

    for (int i = 4; i < 16; i++) wr(4'(i), 32'hC0DE_0000 | i);
    for (int i = 4; i < 16; i++) rd(4'(i), 32'hC0DE_0000 | i, "R1 scratch readback");

    wr(4'd1, 32'h0000_0005);
    rd(4'd1, 32'h0000_0005, "R3 address register readback");

    ctl_wide_i = 1;
    wr(4'd2, 32'hA1B2_C3D4);
    rd(4'd2, 32'hA1B2_C3D4, "R4 wide control word");
    rd(4'd2, 32'hA1B2_C3D4, "R7 no increment reread");
    rd(4'd1, 32'h0000_0005, "R7 address unchanged");

    wr(4'd1, 32'h7);
    wr(4'd2, 32'h0102_0304);
    ctl_wide_i = 0;
    wr(4'd2, 32'h9999_0000);
    wr(4'd1, 32'h7);
    ctl_wide_i = 1;
    rd(4'd2, 32'h0102_0304, "R4 half write not committed");

    ctl_wide_i = 0;
    wr(4'd1, 32'h7);
    wr(4'd2, 32'hDEAD_0000);
    wr(4'd2, 32'hBEEF_0000);
    ctl_wide_i = 1;
    rd(4'd2, 32'hDEAD_BEEF, "R4 two halves high first");
    ctl_wide_i = 0;
    rd(4'd2, 32'hDEAD_0000, "R6 control high half");
    rd(4'd2, 32'hBEEF_0000, "R6 control low half");
    ctl_wide_i = 1;

    wr(4'd1, 32'h0000_800A);
    dwidth_i = 2'd0;
    wr(4'd3, 32'h12FF_FFFF); wr(4'd3, 32'h34FF_FFFF);
    wr(4'd3, 32'h56FF_FFFF); wr(4'd3, 32'h78FF_FFFF);
    wr(4'd3, 32'h9A00_1234); wr(4'd3, 32'hBC00_1234);
    wr(4'd3, 32'hDE00_1234); wr(4'd3, 32'hF000_1234);
    rd(4'd1, 32'h0000_800C, "R7 increments per word");
    wr(4'd1, 32'h0000_800A);
    dwidth_i = 2'd3;
    rd(4'd3, 32'h1234_5678, "R5 byte writes packed big-endian");
    rd(4'd3, 32'h9ABC_DEF0, "R5 second word");
    rd(4'd1, 32'h0000_800C, "R7 wide reads increment");

    wr(4'd1, 32'h0000_800A);
    dwidth_i = 2'd0;
    rd(4'd3, 32'h1200_0000, "R6 byte 0");
    rd(4'd3, 32'h3400_0000, "R6 byte 1");
    rd(4'd3, 32'h5600_0000, "R6 byte 2");
    rd(4'd3, 32'h7800_0000, "R6 byte 3");
    dwidth_i = 2'd1;
    rd(4'd3, 32'h9ABC_0000, "R6 half 0");
    rd(4'd3, 32'hDEF0_0000, "R6 half 1");
    rd(4'd1, 32'h0000_800C, "R7 narrow reads increment per word");

    repeat (2) @(negedge clk);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule